// File: doc/BRIEF.md
# Breathing Pattern Sequencer

This block produces a time-varying brightness value for a set of LED groups. In autonomous mode it walks a four-phase cycle: a rise, a hold at the high level, a fall, and a hold at the low level. Each phase lasts a programmable number of ticks. During the rise and fall phases the brightness moves linearly between the two levels. A loop can begin at any of the four phases and ends either after the high hold or after the low hold. A repeat count limits how many loops run, and a count of zero means the pattern never stops. When the last loop finishes, the output keeps its final value and a done flag is raised. The flag clears when it is read, when a new run starts, or when the pattern is disabled.

In manual mode a switch input selects the high or the low level. The output either jumps to that level on the next clock or walks toward it by one LSB per tick. The tick is a single-cycle enable from a slower time base. All configuration arrives as static register values, and the run and status-read inputs are single-cycle strobes.

Top module: `brth_seq_top`

## Requirements
- R1: After reset, `level_o` is 0 and `done_o` is 0.
- R2: While `pat_en_i` is 0, `level_o` is 0 from the next clock, `done_o` is 0, and a `run_i` strobe starts nothing. When the enable returns, the output stays at 0 until a run.
- R3: Phase encoding: 0 is rise, 1 is high hold, 2 is fall, 3 is low hold. After the last tick of a phase, the sequence moves to the next phase (3 wraps to 0) unless that phase is the loop end. The high hold outputs `hi_lvl_i` and the low hold outputs `lo_lvl_i`.
- R4: With `hi_lvl_i` >= `lo_lvl_i`, after k ticks of a rise of D ticks the output is lo + floor((hi-lo)*k/D). After k ticks of a fall of D ticks it is hi - floor((hi-lo)*k/D). Each ramp reaches its end level on its last tick.
- R5: A phase whose duration is 0 takes no ticks and is passed within one clock.
- R6: `loop_start_i` (encoded as in R3) names the phase where a run begins and where every later loop restarts.
- R7: `loop_end_i` = 2'b00 ends each loop after the low hold (phase 3). Any other value ends it after the high hold (phase 1). The loop count increments at that end point.
- R8: After `repeat_i` (12 bits) loops, the sequence stops, `level_o` holds its final value, and `done_o` goes to 1. With `repeat_i` = 0 the pattern runs forever and `done_o` stays 0.
- R9: `done_o` clears on a `status_rd_i` strobe, on a new run, and when `pat_en_i` falls. A set in the same cycle as a read wins.
- R10: In manual mode (`pat_en_i`=1, `auto_mode_i`=0) with `ramp_en_i`=0, `level_o` equals `hi_lvl_i` when `man_switch_i` is 1 and `lo_lvl_i` when it is 0, one clock later.
- R11: In manual mode with `ramp_en_i`=1, each tick moves `level_o` one LSB toward the selected level. Without a tick it holds.
- R12: A run starts only when both `pat_en_i` and `auto_mode_i` are 1. A strobe in manual mode is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pat_en_i | input | 1 | Pattern controller enable |
| auto_mode_i | input | 1 | 1 selects autonomous mode, 0 selects manual mode |
| run_i | input | 1 | Single-cycle strobe that starts a run |
| status_rd_i | input | 1 | Single-cycle strobe that reads and clears the done flag |
| tick_i | input | 1 | Time-base enable, one cycle per step |
| hi_lvl_i | input | BW | High brightness level |
| lo_lvl_i | input | BW | Low brightness level |
| dur_rise_i | input | TW | Rise duration in ticks |
| dur_on_i | input | TW | High-hold duration in ticks |
| dur_fall_i | input | TW | Fall duration in ticks |
| dur_off_i | input | TW | Low-hold duration in ticks |
| loop_start_i | input | 2 | Phase where a loop begins |
| loop_end_i | input | 2 | Loop end select |
| repeat_i | input | RW | Number of loops, 0 means endless |
| man_switch_i | input | 1 | Manual level select |
| ramp_en_i | input | 1 | Manual smooth ramp enable |
| level_o | output | BW | Current brightness |
| done_o | output | 1 | Pattern finished flag |

## Verification
A wrong phase or tick count shows directly on `level_o` at the next tick. The wrong value is hi where lo is expected, or a ramp point off by a whole step. A skipped or extra advance at a loop boundary moves `done_o` by a full loop length, which is a tick count the bench predicts exactly. A loop counter that drifts is exposed by the runs with a repeat count of two, and by the endless run in which `done_o` must never rise. In manual mode, a wrong level register shows within one clock with ramping off, and as a step larger than one LSB with ramping on.

// File: rtl/brth_pkg.sv
package brth_pkg;
    typedef enum logic [1:0] {
        PH_RISE = 2'd0,
        PH_HIGH = 2'd1,
        PH_FALL = 2'd2,
        PH_LOW  = 2'd3
    } brth_phase_e;
endpackage

// File: rtl/brth_interp.sv
module brth_interp
    import brth_pkg::*;
#(
    parameter int BW = 8,
    parameter int TW = 8
) (
    input  brth_phase_e    phase_i,
    input  logic [TW-1:0]  cnt_i,
    input  logic [TW-1:0]  dur_rise_i,
    input  logic [TW-1:0]  dur_fall_i,
    input  logic [BW-1:0]  hi_i,
    input  logic [BW-1:0]  lo_i,
    output logic [BW-1:0]  val_o
);
    localparam int PW = BW + TW;

    logic [BW-1:0] span;
    logic [TW-1:0] dur_sel;
    logic [PW-1:0] prod;
    logic [PW-1:0] quo;
    logic [BW-1:0] frac;

    always_comb begin
        span    = hi_i - lo_i;
        dur_sel = (phase_i == PH_FALL) ? dur_fall_i : dur_rise_i;
        prod    = PW'(span) * PW'(cnt_i);
        quo     = (dur_sel == '0) ? PW'(span) : prod / PW'(dur_sel);
        frac    = BW'(quo);
        unique case (phase_i)
            PH_RISE: val_o = lo_i + frac;
            PH_HIGH: val_o = hi_i;
            PH_FALL: val_o = hi_i - frac;
            default: val_o = lo_i;
        endcase
    end
endmodule

// File: rtl/brth_step.sv
module brth_step #(
    parameter int BW = 8
) (
    input  logic [BW-1:0] cur_i,
    input  logic [BW-1:0] target_i,
    output logic [BW-1:0] nxt_o
);
    always_comb begin
        if (cur_i < target_i)
            nxt_o = cur_i + BW'(1);
        else if (cur_i > target_i)
            nxt_o = cur_i - BW'(1);
        else
            nxt_o = cur_i;
    end
endmodule

// File: rtl/brth_seq_top.sv
module brth_seq_top
    import brth_pkg::*;
#(
    parameter int BW = 8,
    parameter int TW = 8,
    parameter int RW = 12
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          pat_en_i,
    input  logic          auto_mode_i,
    input  logic          run_i,
    input  logic          status_rd_i,
    input  logic          tick_i,
    input  logic [BW-1:0] hi_lvl_i,
    input  logic [BW-1:0] lo_lvl_i,
    input  logic [TW-1:0] dur_rise_i,
    input  logic [TW-1:0] dur_on_i,
    input  logic [TW-1:0] dur_fall_i,
    input  logic [TW-1:0] dur_off_i,
    input  logic [1:0]    loop_start_i,
    input  logic [1:0]    loop_end_i,
    input  logic [RW-1:0] repeat_i,
    input  logic          man_switch_i,
    input  logic          ramp_en_i,
    output logic [BW-1:0] level_o,
    output logic          done_o
);
    typedef struct packed {
        brth_phase_e   phase;
        logic [TW-1:0] cnt;
        logic [RW-1:0] loops;
        logic          running;
        logic          done;
    } seq_t;

    seq_t          seq_d, seq_q;
    logic [BW-1:0] level_d, level_q;
    logic [TW-1:0] cur_dur;
    brth_phase_e   end_ph;
    logic [1:0]    ph_inc;
    logic [RW-1:0] loops_inc;
    logic          done_set;
    logic [BW-1:0] ramp_val;
    logic [BW-1:0] man_target;
    logic [BW-1:0] man_next;

    always_comb begin
        unique case (seq_q.phase)
            PH_RISE: cur_dur = dur_rise_i;
            PH_HIGH: cur_dur = dur_on_i;
            PH_FALL: cur_dur = dur_fall_i;
            default: cur_dur = dur_off_i;
        endcase
    end

    // Sequencing: phase, tick count, loop count, run and done flags
    always_comb begin
        seq_d     = seq_q;
        done_set  = 1'b0;
        end_ph    = (loop_end_i == 2'b00) ? PH_LOW : PH_HIGH;
        ph_inc    = seq_q.phase + 2'd1;
        loops_inc = seq_q.loops + RW'(1);
        if (!pat_en_i) begin
            seq_d.running = 1'b0;
            seq_d.done    = 1'b0;
        end else if (!auto_mode_i) begin
            seq_d.running = 1'b0;
        end else if (run_i) begin
            seq_d.running = 1'b1;
            seq_d.done    = 1'b0;
            seq_d.loops   = '0;
            seq_d.phase   = brth_phase_e'(loop_start_i);
            seq_d.cnt     = '0;
        end else if (seq_q.running) begin
            if (seq_q.cnt == cur_dur) begin
                if (seq_q.phase == end_ph) begin
                    seq_d.loops = loops_inc;
                    if (repeat_i != '0 && loops_inc == repeat_i) begin
                        seq_d.running = 1'b0;
                        seq_d.done    = 1'b1;
                        done_set      = 1'b1;
                    end else begin
                        seq_d.phase = brth_phase_e'(loop_start_i);
                        seq_d.cnt   = '0;
                    end
                end else begin
                    seq_d.phase = brth_phase_e'(ph_inc);
                    seq_d.cnt   = '0;
                end
            end else if (tick_i) begin
                seq_d.cnt = seq_q.cnt + TW'(1);
            end
        end
        if (status_rd_i && !done_set)
            seq_d.done = 1'b0;
    end

    brth_interp #(.BW(BW), .TW(TW)) u_interp (
        .phase_i    (seq_d.phase),
        .cnt_i      (seq_d.cnt),
        .dur_rise_i (dur_rise_i),
        .dur_fall_i (dur_fall_i),
        .hi_i       (hi_lvl_i),
        .lo_i       (lo_lvl_i),
        .val_o      (ramp_val)
    );

    assign man_target = man_switch_i ? hi_lvl_i : lo_lvl_i;

    brth_step #(.BW(BW)) u_step (
        .cur_i    (level_q),
        .target_i (man_target),
        .nxt_o    (man_next)
    );

    // Output level selection
    always_comb begin
        level_d = level_q;
        if (!pat_en_i)
            level_d = '0;
        else if (!auto_mode_i) begin
            if (!ramp_en_i)
                level_d = man_target;
            else if (tick_i)
                level_d = man_next;
        end else if (seq_d.running)
            level_d = ramp_val;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            seq_q   <= '{phase: PH_RISE, cnt: '0, loops: '0, running: 1'b0, done: 1'b0};
            level_q <= '0;
        end else begin
            seq_q   <= seq_d;
            level_q <= level_d;
        end
    end

    assign level_o = level_q;
    assign done_o  = seq_q.done;
endmodule

// File: rtl/brth_seq_chk.sv
module brth_seq_chk #(
    parameter int BW = 8
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          pat_en_i,
    input logic          auto_mode_i,
    input logic          run_i,
    input logic          status_rd_i,
    input logic          tick_i,
    input logic [BW-1:0] hi_lvl_i,
    input logic [BW-1:0] lo_lvl_i,
    input logic          man_switch_i,
    input logic          ramp_en_i,
    input logic [BW-1:0] level_o,
    input logic          done_o
);
    assert_disabled_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !pat_en_i |=> (level_o == '0 && !done_o));

    assert_done_needs_auto_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(done_o) |-> $past(pat_en_i && auto_mode_i));

    assert_read_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && status_rd_i) |=> !done_o);

    assert_run_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pat_en_i && auto_mode_i && run_i) |=> !done_o);

    assert_manual_jump_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pat_en_i && !auto_mode_i && !ramp_en_i)
        |=> level_o == $past(man_switch_i ? hi_lvl_i : lo_lvl_i));

    assert_manual_step_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pat_en_i && !auto_mode_i && ramp_en_i)
        |=> (level_o == $past(level_o)
             || level_o == BW'($past(level_o) + BW'(1))
             || level_o == BW'($past(level_o) - BW'(1))));

    assert_manual_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pat_en_i && !auto_mode_i && ramp_en_i && !tick_i) |=> $stable(level_o));
endmodule

bind brth_seq_top brth_seq_chk #(.BW(BW)) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .pat_en_i     (pat_en_i),
    .auto_mode_i  (auto_mode_i),
    .run_i        (run_i),
    .status_rd_i  (status_rd_i),
    .tick_i       (tick_i),
    .hi_lvl_i     (hi_lvl_i),
    .lo_lvl_i     (lo_lvl_i),
    .man_switch_i (man_switch_i),
    .ramp_en_i    (ramp_en_i),
    .level_o      (level_o),
    .done_o       (done_o)
);

// File: tb/brth_seq_top_tb.sv
module brth_seq_top_tb;
    localparam int BW = 8;
    localparam int TW = 8;
    localparam int RW = 12;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst_n, pat_en, auto_mode, run, status_rd, tick, man_sw, ramp_en;
    logic [BW-1:0] hi_lvl, lo_lvl, level;
    logic [TW-1:0] d_rise, d_on, d_fall, d_off;
    logic [1:0]    lstart, lend;
    logic [RW-1:0] rpt;
    logic          done;

    brth_seq_top #(.BW(BW), .TW(TW), .RW(RW)) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .pat_en_i(pat_en), .auto_mode_i(auto_mode),
        .run_i(run), .status_rd_i(status_rd), .tick_i(tick),
        .hi_lvl_i(hi_lvl), .lo_lvl_i(lo_lvl),
        .dur_rise_i(d_rise), .dur_on_i(d_on), .dur_fall_i(d_fall), .dur_off_i(d_off),
        .loop_start_i(lstart), .loop_end_i(lend), .repeat_i(rpt),
        .man_switch_i(man_sw), .ramp_en_i(ramp_en), .level_o(level), .done_o(done)
    );

    int errs = 0;
    int checks = 0;

    // Bench model of the autonomous sequence
    int m_ph, m_cnt, m_loops, m_run, m_done;
    int m_hi, m_lo, m_start, m_endsel, m_rpt;
    int dur[4];

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int m_level();
        case (m_ph)
            0: return (dur[0] == 0) ? m_hi : m_lo + ((m_hi - m_lo) * m_cnt) / dur[0];
            1: return m_hi;
            2: return (dur[2] == 0) ? m_lo : m_hi - ((m_hi - m_lo) * m_cnt) / dur[2];
            default: return m_lo;
        endcase
    endfunction

    task automatic m_settle();
        for (int i = 0; i < 8; i++) begin
            if (m_run != 0 && m_cnt == dur[m_ph]) begin
                if (m_ph == ((m_endsel == 0) ? 3 : 1)) begin
                    m_loops++;
                    if (m_rpt != 0 && m_loops == m_rpt) begin
                        m_run = 0;
                        m_done = 1;
                    end else begin
                        m_ph = m_start;
                        m_cnt = 0;
                    end
                end else begin
                    m_ph = (m_ph + 1) % 4;
                    m_cnt = 0;
                end
            end
        end
    endtask

    task automatic apply_cfg();
        @(negedge clk);
        hi_lvl = BW'(m_hi); lo_lvl = BW'(m_lo);
        d_rise = TW'(dur[0]); d_on = TW'(dur[1]); d_fall = TW'(dur[2]); d_off = TW'(dur[3]);
        lstart = 2'(m_start); lend = 2'(m_endsel); rpt = RW'(m_rpt);
    endtask

    task automatic pulse_run();
        @(negedge clk) run = 1'b1;
        @(negedge clk) run = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic start_run();
        pulse_run();
        m_run = 1; m_done = 0; m_loops = 0; m_ph = m_start; m_cnt = 0;
        m_settle();
    endtask

    task automatic do_tick();
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
        repeat (6) @(negedge clk);
        if (m_run != 0 && m_cnt < dur[m_ph]) m_cnt++;
        m_settle();
    endtask

    task automatic pulse_read();
        @(negedge clk) status_rd = 1'b1;
        @(negedge clk) status_rd = 1'b0;
        @(negedge clk);
    endtask

    task automatic set_durs(int ds);
        if (ds == 0) begin dur[0] = 3; dur[1] = 2; dur[2] = 4; dur[3] = 1; end
        else begin dur[0] = 0; dur[1] = 2; dur[2] = 3; dur[3] = 0; end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errs++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; pat_en = 1'b0; auto_mode = 1'b0; run = 1'b0; status_rd = 1'b0;
        tick = 1'b0; man_sw = 1'b0; ramp_en = 1'b0;
        m_hi = 200; m_lo = 20; m_start = 0; m_endsel = 0; m_rpt = 1;
        set_durs(0);
        apply_cfg();
        repeat (3) @(negedge clk);
        chk("R1 level after reset", int'(level), 0);
        chk("R1 done after reset", int'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Sweep of the autonomous sequence
        pat_en = 1'b1; auto_mode = 1'b1;
        for (int lv = 0; lv < 2; lv++) begin
            for (int ds = 0; ds < 2; ds++) begin
                for (int st = 0; st < 4; st++) begin
                    for (int en = 0; en < 2; en++) begin
                        for (int rp = 1; rp <= 2; rp++) begin
                            m_hi = (lv == 0) ? 200 : 7;
                            m_lo = (lv == 0) ? 20 : 0;
                            set_durs(ds);
                            m_start = st; m_endsel = (en == 0) ? 0 : 2; m_rpt = rp;
                            apply_cfg();
                            start_run();
                            chk("R3 R4 R5 R6 start level", int'(level), m_level());
                            chk("R8 done at start", int'(done), m_done);
                            begin
                                int extra = 0;
                                for (int t = 0; t < 30 && extra < 2; t++) begin
                                    if (m_done != 0) extra++;
                                    do_tick();
                                    chk("R3 R4 R5 R6 R7 level", int'(level), m_level());
                                    chk("R7 R8 done", int'(done), m_done);
                                end
                            end
                        end
                    end
                end
            end
        end

        // Endless repeat
        m_hi = 200; m_lo = 20; set_durs(0); m_start = 0; m_endsel = 0; m_rpt = 0;
        apply_cfg();
        start_run();
        for (int t = 0; t < 60; t++) begin
            do_tick();
            if (t % 10 == 9) begin
                chk("R8 endless level", int'(level), m_level());
                chk("R8 endless done stays 0", int'(done), 0);
            end
        end

        // Done clearing: high hold only, one loop of two ticks
        m_start = 1; m_endsel = 1; m_rpt = 1;
        apply_cfg();
        start_run();
        do_tick(); do_tick();
        chk("R8 done after last loop", int'(done), 1);
        chk("R8 level held", int'(level), 200);
        pulse_read();
        chk("R9 done cleared by read", int'(done), 0);
        start_run();
        do_tick(); do_tick();
        chk("R8 done again", int'(done), 1);
        start_run();
        chk("R9 done cleared by new run", int'(done), 0);
        do_tick(); do_tick();
        chk("R8 done third time", int'(done), 1);
        @(negedge clk) pat_en = 1'b0;
        @(negedge clk);
        chk("R9 done cleared by disable", int'(done), 0);
        chk("R2 level zero when disabled", int'(level), 0);
        pulse_run();
        @(negedge clk) pat_en = 1'b1;
        repeat (3) @(negedge clk);
        do_tick();
        chk("R2 run ignored while disabled (level)", int'(level), 0);
        chk("R2 done stays clear after re-enable", int'(done), 0);

        // Manual mode
        m_hi = 14; m_lo = 10; m_start = 1;
        apply_cfg();
        auto_mode = 1'b0; ramp_en = 1'b0; man_sw = 1'b0;
        repeat (2) @(negedge clk);
        chk("R10 manual low", int'(level), 10);
        @(negedge clk) man_sw = 1'b1;
        @(negedge clk);
        chk("R10 manual jump high", int'(level), 14);
        @(negedge clk) man_sw = 1'b0;
        @(negedge clk);
        chk("R10 manual jump low", int'(level), 10);
        @(negedge clk) begin ramp_en = 1'b1; man_sw = 1'b1; end
        repeat (4) @(negedge clk);
        chk("R11 hold without tick", int'(level), 10);
        for (int k = 1; k <= 5; k++) begin
            do_tick();
            chk("R11 ramp up", int'(level), (10 + k > 14) ? 14 : 10 + k);
        end
        @(negedge clk) man_sw = 1'b0;
        for (int k = 1; k <= 5; k++) begin
            do_tick();
            chk("R11 ramp down", int'(level), (14 - k < 10) ? 10 : 14 - k);
        end

        // Run strobe in manual mode is ignored
        ramp_en = 1'b0;
        @(negedge clk);
        pulse_run();
        chk("R12 manual level before switch", int'(level), 10);
        @(negedge clk) auto_mode = 1'b1;
        do_tick(); do_tick(); do_tick();
        chk("R12 run ignored in manual mode", int'(level), 10);
        chk("R12 no done from ignored run", int'(done), 0);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule